// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and date as six packed-BCD bytes: seconds, minutes, hours (24-hour), day of month, month and a two-digit year that stands for 2000 to 2099. A one-cycle tick taken from a 32768 Hz timebase feeds a prescaler. The prescaler advances the seconds once per `TICKS_PER_SEC` ticks, and the carry runs through every field up to the year. Month lengths and leap years are handled. Events are produced once per second and never faster.

Software or a sequencer sets the time one field at a time. It sets a load strobe for the field and puts the value on the shared write data bus. The alarm fields are written the same way. An alarm pulse is raised when the clock advances onto a time equal to all six alarm fields. No field can be masked.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, time reads 00:00:00 on day 01, month 01, year 00, and no event output is high.
- R2: While running, the seconds advance by one only on every `TICKS_PER_SEC`-th tick. `sec_evt_o` pulses for one cycle in the cycle after the tick that completes the second.
- R3: While `run_i` is low, ticks are ignored. The fields hold, no event fires and the prescaler keeps its count.
- R4: Seconds and minutes roll from 59 to 00. `min_evt_o` pulses with the seconds wrap, and `hour_evt_o` pulses with the minutes wrap.
- R5: Hours roll from 23 to 00, and `day_evt_o` pulses with that wrap.
- R6: The day rolls to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other non-February months, and the month rolls from 12 to 01.
- R7: February ends after day 29 when the year value is divisible by 4 (year 00 included). Otherwise it ends after day 28.
- R8: The year rolls from 99 to 00.
- R9: Setting bit k of `time_ld_i` writes `wr_data_i` into field k at the next clock edge. The bit order is 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, and several bits may be set at once. Any time load clears the prescaler to zero and stops the time advancing in that cycle.
- R10: `alarm_ld_i` uses the same bit order to write the alarm fields. `alarm_evt_o` pulses for one cycle when the time advances onto a value equal to all six alarm fields.
- R11: No alarm is raised if any single field differs, and none is raised when a load makes the time equal to the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse per timebase period |
| run_i | input | 1 | Clock advance enable |
| time_ld_i | input | 6 | Per-field time load strobes |
| alarm_ld_i | input | 6 | Per-field alarm load strobes |
| wr_data_i | input | 8 | BCD value for the loaded fields |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, 24-hour |
| day_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month 01..12, BCD |
| year_o | output | 8 | Year 00..99, BCD |
| sec_evt_o | output | 1 | One-second event pulse |
| min_evt_o | output | 1 | Minute rollover pulse |
| hour_evt_o | output | 1 | Hour rollover pulse |
| day_evt_o | output | 1 | Day rollover pulse |
| alarm_evt_o | output | 1 | Alarm match pulse |

## Verification
All results share one latency: one clock edge. A tick that completes a second updates the fields, the four rollover pulses and the alarm pulse at the edge that samples it. A load strobe updates its field at the edge that samples it. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It then compares every output at that same falling edge, which is the only cycle in which the pulses are high. A further falling edge is used to confirm that a pulse has dropped, and the partial-second checks sample after tick TICKS_PER_SEC-1 to confirm that nothing has moved early.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NF      = 6;
  localparam int IX_SEC  = 0;
  localparam int IX_MIN  = 1;
  localparam int IX_HOUR = 2;
  localparam int IX_DAY  = 3;
  localparam int IX_MON  = 4;
  localparam int IX_YEAR = 5;

  typedef logic [7:0] bcd8_t;

  // Reset value of a field: day and month start at 01, the rest at 00.
  function automatic bcd8_t field_reset(int ix);
    return (ix == IX_DAY || ix == IX_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(bcd8_t v);
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  function automatic logic is_leap(bcd8_t yr);
    logic [6:0] b;
    b = bcd_to_bin(yr);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic bcd8_t month_last_day(bcd8_t mon, bcd8_t yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic step_o
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = tick_i && run_i;
  assign step_o = cnt_en && !clr_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (step_o) cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the count never passes the last phase of a second
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R3: with the run control low and no clear, the phase holds
  a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_q));
  // R9: a clear leaves the phase at zero
  a_r9_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_i,
  input  logic [NF-1:0]        ld_mask_i,
  input  bcd8_t                ld_data_i,
  output logic [NF-1:0][7:0]   time_o,
  output logic [NF-1:0][7:0]   next_o,
  output logic                 sec_evt_o,
  output logic                 min_evt_o,
  output logic                 hour_evt_o,
  output logic                 day_evt_o
);
  logic [NF-1:0][7:0] cur;
  logic w_sec, w_min, w_hour, w_day, w_mon;
  logic [3:0] evt_q, evt_d;

  // Carry chain: each wrap needs all lower fields to wrap as well.
  always_comb begin
    w_sec  = (cur[IX_SEC] == 8'h59);
    w_min  = w_sec  && (cur[IX_MIN]  == 8'h59);
    w_hour = w_min  && (cur[IX_HOUR] == 8'h23);
    w_day  = w_hour && (cur[IX_DAY]  == month_last_day(cur[IX_MON], cur[IX_YEAR]));
    w_mon  = w_day  && (cur[IX_MON]  == 8'h12);

    next_o = cur;
    next_o[IX_SEC] = w_sec ? 8'h00 : bcd_inc(cur[IX_SEC]);
    if (w_sec)  next_o[IX_MIN]  = (cur[IX_MIN]  == 8'h59) ? 8'h00 : bcd_inc(cur[IX_MIN]);
    if (w_min)  next_o[IX_HOUR] = (cur[IX_HOUR] == 8'h23) ? 8'h00 : bcd_inc(cur[IX_HOUR]);
    if (w_hour) next_o[IX_DAY]  = w_day ? 8'h01 : bcd_inc(cur[IX_DAY]);
    if (w_day)  next_o[IX_MON]  = w_mon ? 8'h01 : bcd_inc(cur[IX_MON]);
    if (w_mon)  next_o[IX_YEAR] = (cur[IX_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur[IX_YEAR]);
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    bcd8_t q, d;
    always_comb begin
      d = q;
      if (ld_mask_i[i])  d = ld_data_i;
      else if (step_i)   d = next_o[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= field_reset(i);
      else        q <= d;
    end
    assign cur[i] = q;
  end

  always_comb begin
    evt_d = {step_i && w_hour, step_i && w_min, step_i && w_sec, step_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign time_o     = cur;
  assign sec_evt_o  = evt_q[0];
  assign min_evt_o  = evt_q[1];
  assign hour_evt_o = evt_q[2];
  assign day_evt_o  = evt_q[3];

  // R3: without a step or a load every field holds
  a_r3_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && ld_mask_i == '0) |=> $stable(cur));
  // R4: a minute rollover always coincides with a second event
  a_r4_min_has_sec: assert property (@(posedge clk) disable iff (!rst_n)
    min_evt_o |-> sec_evt_o);
  // R4: seconds read 00 whenever a minute event is out
  a_r4_min_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    min_evt_o |-> (cur[IX_SEC] == 8'h00));
  // R5: a day event leaves the clock at midnight
  a_r5_day_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    day_evt_o |-> (cur[IX_HOUR] == 8'h00 && cur[IX_MIN] == 8'h00 && hour_evt_o));
  // R9: a seconds load lands the bus value
  a_r9_sec_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mask_i[IX_SEC] |=> (cur[IX_SEC] == $past(ld_data_i)));

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NF-1:0]      ld_mask_i,
  input  bcd8_t              ld_data_i,
  input  logic               step_i,
  input  logic [NF-1:0][7:0] next_i,
  input  logic [NF-1:0][7:0] time_i,
  output logic               alarm_o
);
  logic [NF-1:0][7:0] alm;
  logic               hit_d, hit_q;

  for (genvar i = 0; i < NF; i++) begin : g_alm
    bcd8_t q, d;
    always_comb begin
      d = q;
      if (ld_mask_i[i]) d = ld_data_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= field_reset(i);
      else        q <= d;
    end
    assign alm[i] = q;
  end

  // Only an advance can raise the alarm; loads never do.
  assign hit_d = step_i && (next_i == alm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign alarm_o = hit_q;

  // R10: the alarm follows an advance of the clock
  a_r10_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> $past(step_i));
  // R11: every field of the new time equals the alarm setting
  a_r11_full_match: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> (time_i == $past(alm)));

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic [5:0] time_ld_i,
  input  logic [5:0] alarm_ld_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] day_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       sec_evt_o,
  output logic       min_evt_o,
  output logic       hour_evt_o,
  output logic       day_evt_o,
  output logic       alarm_evt_o
);
  logic [1:0]         rs_q;
  logic               rst_n_s;
  logic               step;
  logic               any_ld;
  logic [NF-1:0][7:0] cur, nxt;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign any_ld = |time_ld_i;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick_i (tick_i),
    .run_i  (run_i),
    .clr_i  (any_ld),
    .step_o (step)
  );

  rtc_time_chain u_chain (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .step_i     (step),
    .ld_mask_i  (time_ld_i),
    .ld_data_i  (wr_data_i),
    .time_o     (cur),
    .next_o     (nxt),
    .sec_evt_o  (sec_evt_o),
    .min_evt_o  (min_evt_o),
    .hour_evt_o (hour_evt_o),
    .day_evt_o  (day_evt_o)
  );

  rtc_alarm_unit u_alarm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ld_mask_i (alarm_ld_i),
    .ld_data_i (wr_data_i),
    .step_i    (step),
    .next_i    (nxt),
    .time_i    (cur),
    .alarm_o   (alarm_evt_o)
  );

  assign sec_o   = cur[IX_SEC];
  assign min_o   = cur[IX_MIN];
  assign hour_o  = cur[IX_HOUR];
  assign day_o   = cur[IX_DAY];
  assign month_o = cur[IX_MON];
  assign year_o  = cur[IX_YEAR];

  // R2: a second event needs a running tick on the edge before
  a_r2_sec_evt_cause: assert property (@(posedge clk) disable iff (!rst_n_s)
    sec_evt_o |-> $past(tick_i && run_i && !any_ld));
  // R9: a load cycle never yields a second event
  a_r9_load_no_step: assert property (@(posedge clk) disable iff (!rst_n_s)
    any_ld |=> !sec_evt_o);

endmodule

// File: tb/test_rtc_bcd_calendar.sv
module test_rtc_bcd_calendar;
  localparam int TK = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i, run_i;
  logic [5:0] time_ld_i, alarm_ld_i;
  logic [7:0] wr_data_i;
  logic [7:0] sec_o, min_o, hour_o, day_o, month_o, year_o;
  logic       sec_evt_o, min_evt_o, hour_evt_o, day_evt_o, alarm_evt_o;

  int nchk = 0;
  int nfail = 0;
  int cur[6];
  int alm[6];

  always #10 clk = ~clk;

  rtc_bcd_calendar #(.TICKS_PER_SEC(TK)) i_rtc_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
    .time_ld_i(time_ld_i), .alarm_ld_i(alarm_ld_i), .wr_data_i(wr_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
    .month_o(month_o), .year_o(year_o), .sec_evt_o(sec_evt_o),
    .min_evt_o(min_evt_o), .hour_evt_o(hour_evt_o), .day_evt_o(day_evt_o),
    .alarm_evt_o(alarm_evt_o)
  );

  function automatic logic [7:0] tobcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] dut_field(int i);
    case (i)
      0: return sec_o;
      1: return min_o;
      2: return hour_o;
      3: return day_o;
      4: return month_o;
      default: return year_o;
    endcase
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Bench model of one second of advance.
  task automatic calc_next(input int c[6], output int n[6],
                           output bit es, output bit em, output bit eh, output bit ed);
    n = c;
    es = 1; em = 0; eh = 0; ed = 0;
    n[0] = c[0] + 1;
    if (n[0] == 60) begin
      n[0] = 0; em = 1; n[1] = c[1] + 1;
      if (n[1] == 60) begin
        n[1] = 0; eh = 1; n[2] = c[2] + 1;
        if (n[2] == 24) begin
          n[2] = 0; ed = 1; n[3] = c[3] + 1;
          if (n[3] > dim(c[4], c[5])) begin
            n[3] = 1; n[4] = c[4] + 1;
            if (n[4] == 13) begin
              n[4] = 1; n[5] = (c[5] + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic check_all(string req, bit es, bit em, bit eh, bit ed, bit ea);
    string nm[6] = '{"sec", "min", "hour", "day", "month", "year"};
    for (int i = 0; i < 6; i++) chk(req, nm[i], int'(dut_field(i)), int'(tobcd(cur[i])));
    chk(req, "sec_evt", int'(sec_evt_o), int'(es));
    chk(req, "min_evt", int'(min_evt_o), int'(em));
    chk(req, "hour_evt", int'(hour_evt_o), int'(eh));
    chk(req, "day_evt", int'(day_evt_o), int'(ed));
    chk(req, "alarm_evt", int'(alarm_evt_o), int'(ea));
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic load_time(int v[6]);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) time_ld_i = 6'(1 << i); wr_data_i = tobcd(v[i]);
      @(negedge clk) time_ld_i = '0;
      cur[i] = v[i];
    end
  endtask

  task automatic load_alarm(int v[6]);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) alarm_ld_i = 6'(1 << i); wr_data_i = tobcd(v[i]);
      @(negedge clk) alarm_ld_i = '0;
      alm[i] = v[i];
    end
  endtask

  // Full second from a cleared prescaler, then compare against the model.
  task automatic step_sec(string req);
    int n[6];
    bit es, em, eh, ed;
    for (int k = 0; k < TK - 1; k++) pulse_tick();
    calc_next(cur, n, es, em, eh, ed);
    cur = n;
    pulse_tick();
    check_all(req, es, em, eh, ed, cur == alm);
  endtask

  task automatic directed(string req, int s, int mi, int h, int d, int mo, int y);
    int v[6];
    v = '{s, mi, h, d, mo, y};
    load_time(v);
    step_sec(req);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    int v[6];
    int a[6];
    int n[6];
    bit es, em, eh, ed;
    void'($urandom(32'd2024));
    rst_n = 1'b0; tick_i = 1'b0; run_i = 1'b1;
    time_ld_i = '0; alarm_ld_i = '0; wr_data_i = '0;
    cur = '{0, 0, 0, 1, 1, 0};
    alm = '{0, 0, 0, 1, 1, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_all("R1", 0, 0, 0, 0, 0);

    // R2: nothing moves before the last tick of the second
    for (int k = 0; k < TK - 1; k++) pulse_tick();
    check_all("R2", 0, 0, 0, 0, 0);
    pulse_tick();
    cur[0] = 1;
    check_all("R2", 1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R2", "sec_evt drop", int'(sec_evt_o), 0);

    // R3: run low ignores ticks and keeps the prescaler phase
    pulse_tick();
    pulse_tick();
    @(negedge clk) run_i = 1'b0;
    for (int k = 0; k < TK + 2; k++) pulse_tick();
    check_all("R3", 0, 0, 0, 0, 0);
    @(negedge clk) run_i = 1'b1;
    for (int k = 0; k < TK - 3; k++) pulse_tick();
    check_all("R3", 0, 0, 0, 0, 0);
    pulse_tick();
    cur[0] = 2;
    check_all("R3", 1, 0, 0, 0, 0);

    // R9: a load clears the prescaler phase
    pulse_tick();
    pulse_tick();
    @(negedge clk) time_ld_i = 6'b000001; wr_data_i = 8'h30;
    @(negedge clk) time_ld_i = '0;
    cur[0] = 30;
    check_all("R9", 0, 0, 0, 0, 0);
    for (int k = 0; k < TK - 1; k++) pulse_tick();
    check_all("R9", 0, 0, 0, 0, 0);
    pulse_tick();
    cur[0] = 31;
    check_all("R9", 1, 0, 0, 0, 0);
    // R9: two fields at once
    @(negedge clk) time_ld_i = 6'b000110; wr_data_i = 8'h15;
    @(negedge clk) time_ld_i = '0;
    cur[1] = 15; cur[2] = 15;
    check_all("R9", 0, 0, 0, 0, 0);

    // Directed rollovers
    directed("R4", 59, 10, 5, 3, 3, 10);
    directed("R4", 59, 59, 5, 3, 3, 10);
    directed("R5", 59, 59, 23, 3, 3, 10);
    directed("R6", 59, 59, 23, 30, 4, 10);
    directed("R6", 59, 59, 23, 30, 5, 10);
    directed("R6", 59, 59, 23, 31, 1, 10);
    directed("R7", 59, 59, 23, 28, 2, 24);
    directed("R7", 59, 59, 23, 28, 2, 23);
    directed("R7", 59, 59, 23, 29, 2, 0);
    directed("R8", 59, 59, 23, 31, 12, 99);

    // R10: alarm on the next second
    v = '{20, 30, 10, 15, 6, 42};
    load_time(v);
    calc_next(cur, n, es, em, eh, ed);
    load_alarm(n);
    step_sec("R10");
    chk("R10", "alarm flag set", int'(alarm_evt_o), 1);
    @(negedge clk);
    chk("R10", "alarm drop", int'(alarm_evt_o), 0);

    // R11: year differs only
    load_time(v);
    a = n; a[5] = 43;
    load_alarm(a);
    step_sec("R11");
    chk("R11", "alarm year miss", int'(alarm_evt_o), 0);
    // R11: load equal to alarm raises nothing
    load_time(a);
    @(negedge clk);
    chk("R11", "alarm on load", int'(alarm_evt_o), 0);

    // Random mix
    for (int it = 0; it < 200; it++) begin
      v[5] = $urandom % 100;
      v[4] = 1 + $urandom % 12;
      v[3] = ($urandom % 3 == 0) ? dim(v[4], v[5]) : 1 + $urandom % dim(v[4], v[5]);
      v[2] = ($urandom % 2 == 0) ? 23 : $urandom % 24;
      v[1] = ($urandom % 2 == 0) ? 59 : $urandom % 60;
      v[0] = ($urandom % 4 != 0) ? 59 : $urandom % 60;
      calc_next(v, n, es, em, eh, ed);
      a = n;
      if ($urandom % 2 == 0) begin
        int f;
        f = $urandom % 6;
        a[f] = (f >= 3 && f <= 4) ? 1 + (a[f] % 9) : (a[f] + 1) % 24;
        if (a[f] == n[f]) a[f] = (f >= 3 && f <= 4) ? a[f] + 1 : (a[f] + 1) % 24;
      end
      load_alarm(a);
      load_time(v);
      step_sec((a == n) ? "R10" : "R11");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule